// File: doc/BRIEF.md
# Ring-Buffer Address Generator for a DMA Channel

This block produces the source and destination addresses of one DMA channel that runs as a ring buffer. When software raises the run enable, the block captures a 32-bit start address for each side. It also captures the transfer unit (byte or halfword) and a separate increment enable for each side. Each completed-transfer strobe then advances every side that is set to increment, inside a window of 32 transfers. After the 32nd step the address is back at its start, and the cycle repeats until software drops the run enable. No transfer count takes part: the ring runs freely.

Wrapping works by masking the low address bits. A field of 5 bits is used for bytes and 6 bits for halfwords. There is no compare against a terminal count. A 5-bit transfer index counts alongside the addresses. A one-cycle wrap pulse marks the transfer that brings an incrementing address back to its start. Bus arbitration, data movement, channel priority and the non-ring modes belong to other blocks.

Top module: `ring_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both addresses, the transfer index and the wrap pulse become zero, and the block is idle.
- R2: When `run_en` is high in a cycle in which the block is idle, the next edge loads both start addresses and clears the index to 0. It also captures `unit_hw`, `src_inc` and `dst_inc`. A strobe on `xfer_done` in that same cycle does not advance anything.
- R3: With the captured unit byte (`unit_hw` = 0), each strobe while running adds 1 to address bits [4:0] of an incrementing side. The value rolls from 0x1F to 0x00, and bits [31:5] stay unchanged. A ring loaded at 0x00801000 steps up to 0x0080101F and then returns to 0x00801000.
- R4: With the captured unit halfword (`unit_hw` = 1), each strobe adds 2 to bits [5:0]. The value rolls from 0x3E to 0x00, and bits [31:6] stay unchanged. A ring loaded at 0x00801000 reaches 0x0080103E after 31 strobes and 0x00801000 after 32.
- R5: The two sides are independent. A side whose captured increment enable is 0 holds its loaded address for the whole run.
- R6: `xfer_idx` counts the strobes since load, modulo 32. `wrap_pulse` is high for exactly the one cycle after the strobe that takes the index from 31 to 0, and only if at least one side increments.
- R7: Changes on `unit_hw`, `src_inc`, `dst_inc`, `src_start` and `dst_start` while running have no effect until the next load.
- R8: On load the low five bits of each start address are forced to zero.
- R9: A strobe in the cycle where `run_en` falls is still applied. After that the outputs are frozen, and strobes while idle are ignored.
- R10: In a cycle with no strobe and no load, addresses and index hold and `wrap_pulse` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Ring run enable; its rising edge loads the configuration |
| unit_hw | input | 1 | Transfer unit: 0 byte, 1 halfword |
| src_inc | input | 1 | Source side increments |
| dst_inc | input | 1 | Destination side increments |
| src_start | input | 32 | Source ring start address |
| dst_start | input | 32 | Destination ring start address |
| xfer_done | input | 1 | One completed transfer in this cycle |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| xfer_idx | output | 5 | Transfer index within the ring |
| wrap_pulse | output | 1 | One-cycle pulse on ring completion |

## Verification
The hardest state to reach is a complete wrap of 32 strobes in an unbroken run. That wrap should come after the configuration inputs have changed in the middle of the run, or end in a cycle where the enable falls together with a strobe. Random stimulus alone seldom gets there, because any drop of the enable restarts the ring. So the random phase drops the enable only rarely and strobes on most cycles. Directed runs also step exactly 32 strobes through each unit and toggle the configuration inputs halfway.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int SIDES    = 2;
  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;

  typedef struct packed {
    logic             hw;
    logic [SIDES-1:0] inc;
  } ring_cfg_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run_en,
  input  logic      unit_hw,
  input  logic      src_inc,
  input  logic      dst_inc,
  input  logic      xfer_done,
  output logic      load,
  output logic      step,
  output logic      active,
  output ring_cfg_t cfg
);
  // load has priority: a strobe in the load cycle is dropped
  assign load = run_en && !active;
  assign step = active && xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cfg    <= '0;
    end else begin
      active <= run_en;
      if (load) begin
        cfg.hw            <= unit_hw;
        cfg.inc[SIDE_SRC] <= src_inc;
        cfg.inc[SIDE_DST] <= dst_inc;
      end
    end
  end
endmodule

// File: rtl/ring_side.sv
module ring_side #(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          inc,
  input  logic          hw,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] addr
);
  localparam int BYTE_FIELD = IDX_W;
  localparam int HALF_FIELD = IDX_W + 1;

  logic [AW-1:0] mask;
  logic [AW-1:0] incr;
  logic [AW-1:0] sum;
  logic [AW-1:0] nxt;

  always_comb begin
    if (hw) begin
      mask = {{(AW-HALF_FIELD){1'b0}}, {HALF_FIELD{1'b1}}};
      incr = {{(AW-2){1'b0}}, 2'b10};
    end else begin
      mask = {{(AW-BYTE_FIELD){1'b0}}, {BYTE_FIELD{1'b1}}};
      incr = {{(AW-1){1'b0}}, 1'b1};
    end
    sum = addr + incr;
    nxt = (addr & ~mask) | (sum & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= {start[AW-1:IDX_W], {IDX_W{1'b0}}};
    end else if (step && inc) begin
      addr <= nxt;
    end
  end
endmodule

// File: rtl/ring_index.sv
module ring_index #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             any_inc,
  output logic [IDX_W-1:0] idx,
  output logic             wrap
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (load) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (step) begin
      idx  <= idx + 1'b1;
      wrap <= (idx == LAST) && any_inc;
    end else begin
      wrap <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             unit_hw,
  input  logic             src_inc,
  input  logic             dst_inc,
  input  logic [AW-1:0]    src_start,
  input  logic [AW-1:0]    dst_start,
  input  logic             xfer_done,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             wrap_pulse
);
  logic      load;
  logic      step;
  logic      active;
  logic      hw_q;
  ring_cfg_t cfg;

  logic [AW-1:0] start_v [SIDES];
  logic [AW-1:0] addr_v  [SIDES];

  ring_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .unit_hw   (unit_hw),
    .src_inc   (src_inc),
    .dst_inc   (dst_inc),
    .xfer_done (xfer_done),
    .load      (load),
    .step      (step),
    .active    (active),
    .cfg       (cfg)
  );

  assign hw_q              = cfg.hw;
  assign start_v[SIDE_SRC] = src_start;
  assign start_v[SIDE_DST] = dst_start;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ring_side #(.AW(AW), .IDX_W(IDX_W)) u_side (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .step  (step),
      .inc   (cfg.inc[s]),
      .hw    (cfg.hw),
      .start (start_v[s]),
      .addr  (addr_v[s])
    );
  end

  ring_index #(.IDX_W(IDX_W)) u_index (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .any_inc (|cfg.inc),
    .idx     (xfer_idx),
    .wrap    (wrap_pulse)
  );

  assign src_addr = addr_v[SIDE_SRC];
  assign dst_addr = addr_v[SIDE_DST];
endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             xfer_done,
  input logic             active,
  input logic             hw_q,
  input logic [AW-1:0]    src_addr,
  input logic [AW-1:0]    dst_addr,
  input logic [IDX_W-1:0] xfer_idx,
  input logic             wrap_pulse
);
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!xfer_done && !(run_en && !active)) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(xfer_idx))); // R10

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse); // R6

  AST_WRAP_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (xfer_idx == '0)); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && xfer_done) |=> (xfer_idx == IDX_W'($past(xfer_idx) + 1'b1))); // R6

  AST_BYTE_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (active && xfer_done && !hw_q) |=> ($stable(src_addr[AW-1:IDX_W]) && $stable(dst_addr[AW-1:IDX_W]))); // R3

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (active && hw_q) |-> (!src_addr[0] && !dst_addr[0])); // R4

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!active && !run_en) |=> ($stable(src_addr) && $stable(xfer_idx) && !wrap_pulse)); // R9
endmodule

bind ring_addr_gen ring_addr_gen_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .xfer_done  (xfer_done),
  .active     (active),
  .hw_q       (hw_q),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .xfer_idx   (xfer_idx),
  .wrap_pulse (wrap_pulse)
);

// File: tb/ring_addr_gen_test.sv
module ring_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        unit_hw = 1'b0;
  logic        src_inc = 1'b0;
  logic        dst_inc = 1'b0;
  logic [31:0] src_start = '0;
  logic [31:0] dst_start = '0;
  logic        xfer_done = 1'b0;
  logic [31:0] src_addr;
  logic [31:0] dst_addr;
  logic [4:0]  xfer_idx;
  logic        wrap_pulse;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state
  bit          m_act, m_hw, m_si, m_di, m_wrap;
  logic [31:0] m_src, m_dst;
  logic [4:0]  m_idx;

  always #2 clk = ~clk;

  ring_addr_gen uut (
    .clk(clk), .rst(rst), .run_en(run_en), .unit_hw(unit_hw),
    .src_inc(src_inc), .dst_inc(dst_inc), .src_start(src_start),
    .dst_start(dst_start), .xfer_done(xfer_done), .src_addr(src_addr),
    .dst_addr(dst_addr), .xfer_idx(xfer_idx), .wrap_pulse(wrap_pulse)
  );

  function automatic logic [31:0] bump(input logic [31:0] a, input bit hw);
    if (hw) return {a[31:6], a[5:0] + 6'd2};
    return {a[31:5], a[4:0] + 5'd1};
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_act = 0; m_src = '0; m_dst = '0; m_idx = '0; m_wrap = 0;
      m_hw = 0; m_si = 0; m_di = 0;
    end else if (run_en && !m_act) begin
      m_src = src_start & 32'hFFFF_FFE0;
      m_dst = dst_start & 32'hFFFF_FFE0;
      m_hw = unit_hw; m_si = src_inc; m_di = dst_inc;
      m_idx = '0; m_wrap = 0; m_act = 1;
    end else if (m_act && xfer_done) begin
      if (m_si) m_src = bump(m_src, m_hw);
      if (m_di) m_dst = bump(m_dst, m_hw);
      m_wrap = (m_idx == 5'd31) && (m_si || m_di);
      m_idx = m_idx + 5'd1;
      m_act = run_en;
    end else begin
      m_wrap = 0;
      m_act = run_en;
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    n_vec++;
    if (src_addr !== m_src || dst_addr !== m_dst || xfer_idx !== m_idx || wrap_pulse !== m_wrap) begin
      n_fail++;
      $display("FAIL %s: got src=%h dst=%h idx=%0d wrap=%b, expected src=%h dst=%h idx=%0d wrap=%b",
               tag, src_addr, dst_addr, xfer_idx, wrap_pulse, m_src, m_dst, m_idx, m_wrap);
    end
  endtask

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset
    #1;
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0;
    tick("R1 idle after reset");

    // R2 load with a strobe in the load cycle, byte ring on source only
    src_start = 32'h0080_1000; dst_start = 32'h2000_4000;
    unit_hw = 0; src_inc = 1; dst_inc = 0; run_en = 1; xfer_done = 1;
    tick("R2 load ignores strobe");
    expect32("R2 loaded src", src_addr, 32'h0080_1000);
    for (int i = 1; i <= 32; i++) begin
      if (i == 10) begin
        // R7 configuration changes mid-run are ignored
        unit_hw = 1; src_start = 32'hDEAD_BE00; dst_inc = 1; src_inc = 0;
      end
      tick("R3 R5 R7 byte ring");
      if (i == 31) expect32("R3 byte last", src_addr, 32'h0080_101F);
    end
    expect32("R3 byte wrap addr", src_addr, 32'h0080_1000);
    expect32("R6 wrap pulse", {31'd0, wrap_pulse}, 32'd1);
    expect32("R5 dst held", dst_addr, 32'h2000_4000);
    xfer_done = 0;
    tick("R10 hold, R6 pulse ends");
    tick("R10 hold");

    // R9 strobe in the cycle enable falls, then frozen
    xfer_done = 1; run_en = 0;
    tick("R9 last strobe applied");
    expect32("R9 last strobe", src_addr, 32'h0080_1001);
    for (int i = 0; i < 5; i++) tick("R9 frozen while idle");

    // R4 halfword ring, both sides, dst start with bit 5 set
    unit_hw = 1; src_inc = 1; dst_inc = 1;
    src_start = 32'h0080_1000; dst_start = 32'h1234_5620;
    xfer_done = 0; run_en = 1;
    tick("R2 halfword load");
    xfer_done = 1;
    for (int i = 1; i <= 32; i++) begin
      tick("R4 halfword ring");
      if (i == 31) expect32("R4 halfword last", src_addr, 32'h0080_103E);
    end
    expect32("R4 src back at start", src_addr, 32'h0080_1000);
    expect32("R4 dst back at start", dst_addr, 32'h1234_5620);

    // R8 unaligned start, R6 no pulse when neither side increments
    run_en = 0; xfer_done = 0;
    tick("R9 disable");
    src_start = 32'hABCD_EF17; dst_start = 32'h0000_003F;
    src_inc = 0; dst_inc = 0; unit_hw = 0; run_en = 1;
    tick("R8 load unaligned");
    expect32("R8 src low bits cleared", src_addr, 32'hABCD_EF00);
    expect32("R8 dst low bits cleared", dst_addr, 32'h0000_0020);
    xfer_done = 1;
    for (int i = 0; i < 34; i++) tick("R6 R5 no increment side");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      run_en    = ($urandom % 128) != 0;
      xfer_done = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) begin
        unit_hw   = $urandom;
        src_inc   = $urandom;
        dst_inc   = $urandom;
        src_start = $urandom;
        dst_start = $urandom;
      end
      rst = ($urandom % 2000) == 0;
      tick("R3 R4 R5 R6 R7 R9 R10 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule